// File: doc/BRIEF.md
# Per-Program Lookup Key Extractor

This pipeline stage sits between a header parser and a match-action lookup. Each arriving header vector comes with a program identifier that the parser has attached. The identifier names the program that owns the packet. The stage uses that identifier to pick one entry from a small register table. The chosen entry names which 32-bit header slots are packed into the lookup key and which key slots are live. Because the entry is chosen again for every packet, several programs share one physical stage, and the stage can switch between them on every clock.

The header vector and its identifier travel alongside the configuration read. The key, its mask and the untouched vector therefore leave the stage together, three clocks after the vector arrives. A new vector is accepted on every clock.

Table entries are written through a separate configuration path that is chained from stage to stage. A configuration word carries a stage number, an entry address and the entry contents. The stage whose number matches keeps the word and writes the entry. Any other word is passed on to the next stage one clock later. Writes happen while traffic flows, and a write touches only the entry it addresses.

Top module: `keyx_stage`

## Requirements
- R1: A synchronous active-high `rst` clears `out_vld`, `out_key_vld` and `cfg_out_vld` and marks every table entry invalid. A packet sent after reset, before any configuration is written, comes out with `out_key_vld` low.
- R2: A vector sampled with `in_vld` high appears on `out_vld`, `out_phv` and `out_pid` exactly three clocks later, with its value unchanged. `out_vld` is low three clocks after a clock in which `in_vld` was low.
- R3: An entry is 37 bits. Bits [5k+4:5k] hold the header slot index for key slot k (k = 0..5). Bits [35:30] hold the key mask, with bit 30+k belonging to key slot k. Bit 36 is the entry-valid flag. For a valid entry, key slot k (`out_key[32k+31:32k]`) equals header slot `sel_k` (`in_phv[32*sel_k+31:32*sel_k]`) when mask bit k is set, and is zero when it is clear.
- R4: A slot index of 24 to 31 names no header slot, and the matching key slot is zero even when its mask bit is set.
- R5: A packet whose program identifier selects an invalid entry leaves with `out_key` zero, `out_key_mask` zero and `out_key_vld` low, while `out_vld` stays high.
- R6: Back-to-back packets of different programs each get the key defined by their own program's entry, with a new packet accepted on every clock.
- R7: A configuration word with `cfg_in_vld` high and `cfg_in_stage` equal to `STAGE_ID` writes `cfg_in_data` into entry `cfg_in_addr`, and `cfg_out_vld` is low on the next clock.
- R8: A configuration word whose stage number differs from `STAGE_ID` appears unchanged on the `cfg_out_*` ports one clock later and writes no entry.
- R9: A packet uses the table contents that hold after the clock edge that sampled it. A write sampled on the same edge as the packet is seen by that packet. A write sampled on a later edge is not seen by it. A write to one entry never changes the keys of packets of other programs.
- R10: For a valid entry, `out_key_mask` equals the entry's mask field and `out_key_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input header vector valid |
| in_phv | input | 768 | Header vector, 24 slots of 32 bits, slot 0 in the low bits |
| in_pid | input | 4 | Program identifier of the packet |
| out_vld | output | 1 | Output vector valid |
| out_phv | output | 768 | Header vector, delayed and unchanged |
| out_pid | output | 4 | Program identifier, delayed |
| out_key | output | 192 | Lookup key, 6 slots of 32 bits, slot 0 in the low bits |
| out_key_mask | output | 6 | Live key slots |
| out_key_vld | output | 1 | Key valid (the program's entry is valid) |
| cfg_in_vld | input | 1 | Configuration word valid |
| cfg_in_stage | input | 4 | Target stage number |
| cfg_in_addr | input | 4 | Entry address (program identifier) |
| cfg_in_data | input | 37 | Entry contents |
| cfg_out_vld | output | 1 | Forwarded configuration word valid |
| cfg_out_stage | output | 4 | Forwarded stage number |
| cfg_out_addr | output | 4 | Forwarded entry address |
| cfg_out_data | output | 37 | Forwarded entry contents |

## Verification
A corrupted table entry stays hidden until a packet of that program passes through. It then shows up as a wrong key slot, mask or key-valid flag exactly three clocks after that packet enters. Entries of other programs keep producing correct keys. A bad pipeline register shows up as a shifted or mismatched vector, identifier or key on the very next output clock. A wrong stage-number decode shows up one clock later as a missing or extra word on the forwarding port, and later as stale keys. The bench therefore mixes programs packet by packet and times writes against packets to within a single clock.

// File: rtl/keyx_pkg.sv
package keyx_pkg;
    localparam int PID_W  = 4;
    localparam int NPROG  = 1 << PID_W;
    localparam int NSLOT  = 24;
    localparam int SLOT_W = 32;
    localparam int NKEY   = 6;
    localparam int SID_W  = 4;
    localparam int SEL_W  = $clog2(NSLOT);
    localparam int PHV_W  = NSLOT * SLOT_W;
    localparam int KEY_W  = NKEY * SLOT_W;
    localparam int ENT_W  = 1 + NKEY + NKEY * SEL_W;

    typedef logic [NSLOT-1:0][SLOT_W-1:0] phv_t;
    typedef logic [NKEY-1:0][SLOT_W-1:0]  key_t;

    // entry layout: valid at top, then mask, then slot indices (key slot 0 lowest)
    typedef struct packed {
        logic                       vld;
        logic [NKEY-1:0]            mask;
        logic [NKEY-1:0][SEL_W-1:0] sel;
    } ent_t;

    typedef struct packed {
        logic             vld;
        logic [SID_W-1:0] sid;
        logic [PID_W-1:0] addr;
        ent_t             ent;
    } cfg_word_t;
endpackage

// File: rtl/keyx_cfg_table.sv
module keyx_cfg_table
    import keyx_pkg::*;
#(
    parameter logic [SID_W-1:0] STAGE_ID = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_word_t        cfg_i,
    output cfg_word_t        cfg_o,
    input  logic [PID_W-1:0] rd_pid,
    output ent_t             rd_ent
);
    typedef struct packed {
        ent_t [NPROG-1:0] tbl;
        cfg_word_t        fwd;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.fwd = '0;
        if (cfg_i.vld) begin
            if (cfg_i.sid == STAGE_ID) begin
                st_d.tbl[cfg_i.addr] = cfg_i.ent;
            end else begin
                st_d.fwd = cfg_i;
            end
        end
        if (rst) begin
            for (int i = 0; i < NPROG; i++) begin
                st_d.tbl[i].vld = 1'b0;
            end
            st_d.fwd.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_ent = st_q.tbl[rd_pid];
    assign cfg_o  = st_q.fwd;
endmodule

// File: rtl/keyx_key_build.sv
module keyx_key_build
    import keyx_pkg::*;
(
    input  phv_t            phv,
    input  ent_t            ent,
    output key_t            key,
    output logic [NKEY-1:0] mask,
    output logic            hit
);
    always_comb begin
        key = '0;
        for (int k = 0; k < NKEY; k++) begin
            if (ent.vld && ent.mask[k] && (int'(ent.sel[k]) < NSLOT)) begin
                key[k] = phv[ent.sel[k]];
            end
        end
        mask = ent.vld ? ent.mask : '0;
        hit  = ent.vld;
    end
endmodule

// File: rtl/keyx_stage.sv
module keyx_stage
    import keyx_pkg::*;
#(
    parameter logic [SID_W-1:0] STAGE_ID = 4'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [PHV_W-1:0]  in_phv,
    input  logic [PID_W-1:0]  in_pid,
    output logic              out_vld,
    output logic [PHV_W-1:0]  out_phv,
    output logic [PID_W-1:0]  out_pid,
    output logic [KEY_W-1:0]  out_key,
    output logic [NKEY-1:0]   out_key_mask,
    output logic              out_key_vld,
    input  logic              cfg_in_vld,
    input  logic [SID_W-1:0]  cfg_in_stage,
    input  logic [PID_W-1:0]  cfg_in_addr,
    input  logic [ENT_W-1:0]  cfg_in_data,
    output logic              cfg_out_vld,
    output logic [SID_W-1:0]  cfg_out_stage,
    output logic [PID_W-1:0]  cfg_out_addr,
    output logic [ENT_W-1:0]  cfg_out_data
);
    // stage 1: arrival; stage 2: entry read; stage 3: key registered
    typedef struct packed {
        logic             vld;
        logic [PID_W-1:0] pid;
        phv_t             phv;
    } arr_t;

    typedef struct packed {
        logic             vld;
        logic [PID_W-1:0] pid;
        phv_t             phv;
        ent_t             ent;
    } rd_t;

    typedef struct packed {
        logic             vld;
        logic [PID_W-1:0] pid;
        phv_t             phv;
        key_t             key;
        logic [NKEY-1:0]  mask;
        logic             kvld;
    } res_t;

    typedef struct packed {
        arr_t arr;
        rd_t  rd;
        res_t res;
    } pipe_t;

    pipe_t           pipe_d, pipe_q;
    cfg_word_t       cfg_in_w, cfg_out_w;
    ent_t            tbl_ent;
    key_t            bld_key;
    logic [NKEY-1:0] bld_mask;
    logic            bld_hit;

    assign cfg_in_w.vld  = cfg_in_vld;
    assign cfg_in_w.sid  = cfg_in_stage;
    assign cfg_in_w.addr = cfg_in_addr;
    assign cfg_in_w.ent  = ent_t'(cfg_in_data);

    keyx_cfg_table #(.STAGE_ID(STAGE_ID)) i_tbl (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg_in_w),
        .cfg_o  (cfg_out_w),
        .rd_pid (pipe_q.arr.pid),
        .rd_ent (tbl_ent)
    );

    keyx_key_build i_build (
        .phv  (pipe_q.rd.phv),
        .ent  (pipe_q.rd.ent),
        .key  (bld_key),
        .mask (bld_mask),
        .hit  (bld_hit)
    );

    always_comb begin
        pipe_d.arr.vld = in_vld;
        pipe_d.arr.pid = in_pid;
        pipe_d.arr.phv = phv_t'(in_phv);

        pipe_d.rd.vld  = pipe_q.arr.vld;
        pipe_d.rd.pid  = pipe_q.arr.pid;
        pipe_d.rd.phv  = pipe_q.arr.phv;
        pipe_d.rd.ent  = tbl_ent;

        pipe_d.res.vld  = pipe_q.rd.vld;
        pipe_d.res.pid  = pipe_q.rd.pid;
        pipe_d.res.phv  = pipe_q.rd.phv;
        pipe_d.res.key  = bld_key;
        pipe_d.res.mask = bld_mask;
        pipe_d.res.kvld = pipe_q.rd.vld && bld_hit;

        if (rst) begin
            pipe_d.arr.vld  = 1'b0;
            pipe_d.rd.vld   = 1'b0;
            pipe_d.res.vld  = 1'b0;
            pipe_d.res.kvld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    assign out_vld      = pipe_q.res.vld;
    assign out_phv      = pipe_q.res.phv;
    assign out_pid      = pipe_q.res.pid;
    assign out_key      = pipe_q.res.key;
    assign out_key_mask = pipe_q.res.mask;
    assign out_key_vld  = pipe_q.res.kvld;

    assign cfg_out_vld   = cfg_out_w.vld;
    assign cfg_out_stage = cfg_out_w.sid;
    assign cfg_out_addr  = cfg_out_w.addr;
    assign cfg_out_data  = cfg_out_w.ent;
endmodule

// File: rtl/keyx_stage_chk.sv
module keyx_stage_chk
    import keyx_pkg::*;
#(
    parameter logic [SID_W-1:0] STAGE_ID = 4'd2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [PHV_W-1:0]  in_phv,
    input logic [PID_W-1:0]  in_pid,
    input logic              out_vld,
    input logic [PHV_W-1:0]  out_phv,
    input logic [PID_W-1:0]  out_pid,
    input logic [KEY_W-1:0]  out_key,
    input logic [NKEY-1:0]   out_key_mask,
    input logic              out_key_vld,
    input logic              cfg_in_vld,
    input logic [SID_W-1:0]  cfg_in_stage,
    input logic [PID_W-1:0]  cfg_in_addr,
    input logic [ENT_W-1:0]  cfg_in_data,
    input logic              cfg_out_vld,
    input logic [SID_W-1:0]  cfg_out_stage,
    input logic [PID_W-1:0]  cfg_out_addr,
    input logic [ENT_W-1:0]  cfg_out_data
);
    a_r2_lat_pid: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> ##3 (out_vld && out_pid == $past(in_pid, 3)));

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_vld |-> ##3 !out_vld);

    a_r1_kvld_qual: assert property (@(posedge clk) disable iff (rst)
        out_key_vld |-> out_vld);

    a_r5_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_key_vld) |-> (out_key == '0 && out_key_mask == '0));

    a_r8_forward: assert property (@(posedge clk) disable iff (rst)
        (cfg_in_vld && cfg_in_stage != STAGE_ID) |=>
            (cfg_out_vld && cfg_out_stage == $past(cfg_in_stage)
             && cfg_out_addr == $past(cfg_in_addr) && cfg_out_data == $past(cfg_in_data)));

    a_r7_consume: assert property (@(posedge clk) disable iff (rst)
        !(cfg_in_vld && cfg_in_stage != STAGE_ID) |=> !cfg_out_vld);

    for (genvar k = 0; k < NKEY; k++) begin : g_slot
        a_r3_unmasked_zero: assert property (@(posedge clk) disable iff (rst)
            (out_vld && !out_key_mask[k]) |-> (out_key[k*SLOT_W +: SLOT_W] == '0));
    end
endmodule

bind keyx_stage keyx_stage_chk #(.STAGE_ID(STAGE_ID)) i_keyx_stage_chk (.*);

// File: tb/test_keyx_stage.sv
`timescale 1ns/1ps
module test_keyx_stage;
    import keyx_pkg::*;

    localparam logic [SID_W-1:0] MY_SID = 4'd2;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_vld;
    logic [PHV_W-1:0]  in_phv;
    logic [PID_W-1:0]  in_pid;
    logic              out_vld;
    logic [PHV_W-1:0]  out_phv;
    logic [PID_W-1:0]  out_pid;
    logic [KEY_W-1:0]  out_key;
    logic [NKEY-1:0]   out_key_mask;
    logic              out_key_vld;
    logic              cfg_in_vld;
    logic [SID_W-1:0]  cfg_in_stage;
    logic [PID_W-1:0]  cfg_in_addr;
    logic [ENT_W-1:0]  cfg_in_data;
    logic              cfg_out_vld;
    logic [SID_W-1:0]  cfg_out_stage;
    logic [PID_W-1:0]  cfg_out_addr;
    logic [ENT_W-1:0]  cfg_out_data;

    always #2.5 clk = ~clk;

    keyx_stage #(.STAGE_ID(MY_SID)) i_keyx_stage (.*);

    typedef struct {
        bit                vld;
        logic [PID_W-1:0]  pid;
        logic [PHV_W-1:0]  phv;
        logic [KEY_W-1:0]  key;
        logic [NKEY-1:0]   mask;
        bit                kvld;
        string             tag;
    } exp_t;

    exp_t              pipe [3];
    logic [ENT_W-1:0]  shadow [NPROG];
    bit                ecfg_vld;
    logic [SID_W-1:0]  ecfg_sid;
    logic [PID_W-1:0]  ecfg_addr;
    logic [ENT_W-1:0]  ecfg_data;
    int                n_chk  = 0;
    int                n_fail = 0;
    bit                done   = 0;

    task automatic chk(string req, logic [PHV_W-1:0] act, logic [PHV_W-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [ENT_W-1:0] mk_ent(bit v, logic [5:0] m,
        int s0, int s1, int s2, int s3, int s4, int s5);
        logic [ENT_W-1:0] e;
        e = '0;
        e[36] = v;
        e[35:30] = m;
        e[4:0] = 5'(s0);  e[9:5] = 5'(s1);   e[14:10] = 5'(s2);
        e[19:15] = 5'(s3); e[24:20] = 5'(s4); e[29:25] = 5'(s5);
        return e;
    endfunction

    function automatic logic [KEY_W-1:0] exp_key(logic [PHV_W-1:0] phv, logic [ENT_W-1:0] e);
        logic [KEY_W-1:0] k;
        k = '0;
        if (e[36]) begin
            for (int i = 0; i < NKEY; i++) begin
                int s;
                s = int'(e[5*i +: 5]);
                if (e[30+i] && s < NSLOT) k[32*i +: 32] = phv[32*s +: 32];
            end
        end
        return k;
    endfunction

    function automatic logic [PHV_W-1:0] rnd_phv();
        logic [PHV_W-1:0] p;
        for (int i = 0; i < NSLOT; i++) p[32*i +: 32] = $urandom();
        return p;
    endfunction

    // one clock: check outputs, update model, drive next inputs
    task automatic step(bit pv, logic [PID_W-1:0] pid, logic [PHV_W-1:0] phv,
                        bit cv, logic [SID_W-1:0] sid, logic [PID_W-1:0] addr,
                        logic [ENT_W-1:0] data, string tag);
        logic [ENT_W-1:0] e;
        @(negedge clk);
        chk("R2 out_vld", PHV_W'(out_vld), PHV_W'(pipe[2].vld));
        if (pipe[2].vld) begin
            chk("R2 out_phv", out_phv, pipe[2].phv);
            chk("R2 out_pid", PHV_W'(out_pid), PHV_W'(pipe[2].pid));
            chk({pipe[2].tag, " out_key"}, PHV_W'(out_key), PHV_W'(pipe[2].key));
            chk({pipe[2].tag, " R10 out_key_mask"}, PHV_W'(out_key_mask), PHV_W'(pipe[2].mask));
            chk({pipe[2].tag, " R10 out_key_vld"}, PHV_W'(out_key_vld), PHV_W'(pipe[2].kvld));
        end
        chk("R7/R8 cfg_out_vld", PHV_W'(cfg_out_vld), PHV_W'(ecfg_vld));
        if (ecfg_vld) begin
            chk("R8 cfg_out_stage", PHV_W'(cfg_out_stage), PHV_W'(ecfg_sid));
            chk("R8 cfg_out_addr", PHV_W'(cfg_out_addr), PHV_W'(ecfg_addr));
            chk("R8 cfg_out_data", PHV_W'(cfg_out_data), PHV_W'(ecfg_data));
        end
        ecfg_vld  = cv && (sid != MY_SID);
        ecfg_sid  = sid;
        ecfg_addr = addr;
        ecfg_data = data;
        if (cv && sid == MY_SID) shadow[addr] = data;
        pipe[2] = pipe[1];
        pipe[1] = pipe[0];
        e = shadow[pid];
        pipe[0].vld  = pv;
        pipe[0].pid  = pid;
        pipe[0].phv  = phv;
        pipe[0].key  = exp_key(phv, e);
        pipe[0].mask = e[36] ? e[35:30] : '0;
        pipe[0].kvld = e[36];
        pipe[0].tag  = e[36] ? tag : "R5";
        in_vld       = pv;
        in_pid       = pid;
        in_phv       = phv;
        cfg_in_vld   = cv;
        cfg_in_stage = sid;
        cfg_in_addr  = addr;
        cfg_in_data  = data;
    endtask

    task automatic pkt(logic [PID_W-1:0] pid, string tag);
        step(1, pid, rnd_phv(), 0, '0, '0, '0, tag);
    endtask

    task automatic wr(logic [SID_W-1:0] sid, logic [PID_W-1:0] addr, logic [ENT_W-1:0] d);
        step(0, '0, '0, 1, sid, addr, d, "R7");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, 0, '0, '0, '0, "R2");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0; cfg_in_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out_vld in reset", PHV_W'(out_vld), '0);
        chk("R1 out_key_vld in reset", PHV_W'(out_key_vld), '0);
        chk("R1 cfg_out_vld in reset", PHV_W'(cfg_out_vld), '0);
        for (int i = 0; i < NPROG; i++) shadow[i][36] = 1'b0;
        for (int i = 0; i < 3; i++) pipe[i].vld = 0;
        ecfg_vld = 0;
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual run still busy, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [PHV_W-1:0] p;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        in_vld = 0; in_phv = '0; in_pid = '0;
        cfg_in_vld = 0; cfg_in_stage = '0; cfg_in_addr = '0; cfg_in_data = '0;
        for (int i = 0; i < NPROG; i++) shadow[i] = '0;
        for (int i = 0; i < 3; i++) pipe[i] = '{0, '0, '0, '0, '0, 0, "R2"};
        ecfg_vld = 0;
        do_reset();

        // R1: no entry configured yet
        pkt(4'd3, "R1");
        idle(3);

        // R7: program 3 full key, program 5 with out-of-range indices (R4) and partial mask
        wr(MY_SID, 4'd3, mk_ent(1, 6'b111111, 0, 5, 23, 1, 2, 3));
        wr(MY_SID, 4'd5, mk_ent(1, 6'b101101, 24, 7, 31, 9, 25, 23));
        pkt(4'd3, "R3");
        pkt(4'd5, "R4");
        // R8: words for other stages pass on, table untouched
        wr(4'd7, 4'd3, mk_ent(1, 6'b000001, 4, 4, 4, 4, 4, 4));
        wr(4'd0, 4'd5, '0);
        pkt(4'd3, "R8");
        pkt(4'd5, "R8");
        // R6: back-to-back alternating programs
        for (int i = 0; i < 8; i++) pkt((i % 2) ? 4'd5 : 4'd3, "R6");
        // R9: write sampled with the packet is seen; a write one clock later is not
        p = rnd_phv();
        step(1, 4'd3, p, 1, MY_SID, 4'd3, mk_ent(1, 6'b010010, 0, 11, 0, 0, 12, 0), "R9");
        step(1, 4'd3, p, 1, MY_SID, 4'd3, mk_ent(1, 6'b000111, 20, 21, 22, 0, 0, 0), "R9");
        step(1, 4'd5, p, 1, MY_SID, 4'd3, mk_ent(0, 6'b111111, 1, 1, 1, 1, 1, 1), "R9");
        pkt(4'd5, "R9");
        pkt(4'd3, "R5");
        idle(4);

        // mixed random traffic and writes
        for (int i = 0; i < 3000; i++) begin
            bit cv;
            logic [SID_W-1:0] sid;
            cv  = ($urandom_range(0, 3) == 0);
            sid = ($urandom_range(0, 2) == 0) ? SID_W'($urandom()) : MY_SID;
            step($urandom_range(0, 4) != 0, PID_W'($urandom()), rnd_phv(),
                 cv, sid, PID_W'($urandom()),
                 {($urandom_range(0, 5) != 0), 6'($urandom()), 30'($urandom())}, "R6");
        end
        idle(4);

        // R1: reset mid-run invalidates entries again
        do_reset();
        pkt(4'd3, "R1");
        pkt(4'd5, "R1");
        idle(4);

        done = 1;
        summary();
        $finish;
    end
endmodule